// File: doc/BRIEF.md
# Line Fill Buffer Pool

This block keeps a small set of miss-tracking entries between a level-1 data cache and the next memory level. When a load or store misses in the cache, the requester offers the missing line address and its hardware thread on a ready/valid port. The pool either merges the miss into an entry that already tracks the same line, or claims a free entry and issues a one-cycle line request that carries the entry tag. Refill beats come back tagged with that entry and a beat index, in any order. Once every beat of the line is present, the entry offers the whole line on a cache write port and is released after the write is taken.

Each entry is a three-state machine. In state ENT_FREE the entry holds nothing. The transition ALLOC moves it to ENT_FILL, where it gathers beats under a received-beat mask. The transition LAST_BEAT, taken when the mask fills, moves it to ENT_WRITE. The transition RETIRE, taken when the cache accepts the line, returns it to ENT_FREE. The two hardware threads share entries by demand with no fixed split. Two counters report how many entries each thread holds.

Top module: `lfb_pool`

## Requirements
- R1: After reset no entry is held: miss_ready is 1, wr_valid is 0, mreq_valid is 0, and cnt_t0 and cnt_t1 are 0.
- R2: An accepted miss whose address matches no held entry claims the lowest-numbered free entry. In the next cycle only, mreq_valid is 1, with mreq_addr equal to the miss address and mreq_tag equal to that entry number.
- R3: An accepted miss whose address matches a held entry merges into it. No entry is claimed, mreq_valid stays 0 and both counts are unchanged.
- R4: miss_ready is 0 exactly when every entry is held. A miss offered then is not accepted, claims nothing and issues no request.
- R5: A refill beat with index b (fill_beat, 0..3) for entry fill_tag is placed in bits [b*BEAT_W +: BEAT_W] of the line. Beats may arrive in any of the 24 orders.
- R6: An entry asserts wr_valid only after all four of its beats have been received, and never before.
- R7: When several entries hold complete lines, the lowest-numbered one is shown on wr_addr/wr_data. wr_valid stays 1 until wr_ready is given.
- R8: An entry whose line write is accepted is free in the next cycle, and a miss in that cycle may claim it again.
- R9: cnt_t0 and cnt_t1 count the held entries owned by thread 0 and thread 1 (miss_tid), updated on every claim and release. One thread may hold every entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss offered |
| miss_ready | output | 1 | Pool can take a miss |
| miss_addr | input | ADDR_W | Missing line address |
| miss_tid | input | 1 | Thread that missed |
| mreq_valid | output | 1 | One-cycle line request to next level |
| mreq_addr | output | ADDR_W | Requested line address |
| mreq_tag | output | TAG_W | Entry that will receive the refill |
| fill_valid | input | 1 | Refill beat present |
| fill_tag | input | TAG_W | Entry the beat belongs to |
| fill_beat | input | BEAT_IW | Beat position within the line |
| fill_data | input | BEAT_W | Beat data |
| wr_valid | output | 1 | Complete line offered to the cache |
| wr_ready | input | 1 | Cache takes the line |
| wr_addr | output | ADDR_W | Address of the offered line |
| wr_data | output | LINE_W | Offered line, beat 0 in the low bits |
| cnt_t0 | output | CNT_W | Entries held by thread 0 |
| cnt_t1 | output | CNT_W | Entries held by thread 1 |

## Verification
The bench builds the pool with four entries, 12-bit line addresses and 8-bit beats. This keeps the line at 32 bits and lets a few misses fill the pool. With that size the bench can sweep all 24 beat arrival orders, with each line value computed arithmetically from its seed. It can also drive a single thread to own every entry, offer a miss to a full pool, and release a middle entry to watch it be claimed again. Merging and the lowest-index choice between two complete lines are also within reach at this size.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
    typedef enum logic [1:0] {
        ENT_FREE  = 2'd0,
        ENT_FILL  = 2'd1,
        ENT_WRITE = 2'd2
    } ent_state_e;
endpackage

// File: rtl/lfb_pick.sv
module lfb_pick #(
    parameter int N  = 10,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign seen[i+1] = seen[i] | req[i];
        assign gnt[i]    = req[i] & ~seen[i];
    end

    assign any = seen[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/lfb_entry.sv
module lfb_entry
    import lfb_pkg::*;
#(
    parameter int ADDR_W  = 26,
    parameter int BEATS   = 4,
    parameter int BEAT_W  = 128,
    parameter int BEAT_IW = $clog2(BEATS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_en,
    input  logic [ADDR_W-1:0]       alloc_addr,
    input  logic                    alloc_tid,
    input  logic                    fill_en,
    input  logic [BEAT_IW-1:0]      fill_beat,
    input  logic [BEAT_W-1:0]       fill_data,
    input  logic                    wr_grant,
    output logic                    busy,
    output logic                    want_write,
    output logic [ADDR_W-1:0]       line_addr,
    output logic                    owner,
    output logic [BEATS*BEAT_W-1:0] line_data
);
    ent_state_e state_q, state_d;

    logic [BEATS-1:0]             mask_q;
    logic [BEATS-1:0]             mask_nx;
    logic [BEATS-1:0]             beat_bit;
    logic [BEATS-1:0][BEAT_W-1:0] data_q;
    logic [ADDR_W-1:0]            addr_q;
    logic                         tid_q;
    logic                         fill_take;

    assign beat_bit  = BEATS'(1) << fill_beat;
    assign fill_take = fill_en && (state_q == ENT_FILL);
    assign mask_nx   = mask_q | (fill_take ? beat_bit : '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENT_FREE;
        else        state_q <= state_d;
    end

    // transitions: ALLOC, LAST_BEAT, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_FREE:  if (alloc_en)  state_d = ENT_FILL;
            ENT_FILL:  if (&mask_nx)  state_d = ENT_WRITE;
            ENT_WRITE: if (wr_grant)  state_d = ENT_FREE;
            default:                  state_d = ENT_FREE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state_q != ENT_FREE);
        want_write = (state_q == ENT_WRITE);
        line_addr  = addr_q;
        owner      = tid_q;
        line_data  = data_q;
    end

    // line contents
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            addr_q <= '0;
            tid_q  <= 1'b0;
            data_q <= '0;
        end else if (alloc_en && state_q == ENT_FREE) begin
            mask_q <= '0;
            addr_q <= alloc_addr;
            tid_q  <= alloc_tid;
        end else if (fill_take) begin
            mask_q            <= mask_nx;
            data_q[fill_beat] <= fill_data;
        end
    end

    AST_WRITE_NEEDS_ALL_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        want_write |-> (&mask_q)); // R6
    AST_CLAIM_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !busy); // R2
    AST_FREE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_grant |=> !busy); // R8
endmodule

// File: rtl/lfb_thread_count.sv
module lfb_thread_count #(
    parameter int N     = 10,
    parameter int CNT_W = $clog2(N + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   inc_en,
    input  logic                   inc_tid,
    input  logic                   dec_en,
    input  logic                   dec_tid,
    output logic [1:0][CNT_W-1:0]  cnt
);
    for (genvar t = 0; t < 2; t++) begin : g_thr
        logic             up, dn;
        logic [CNT_W-1:0] c_q;

        assign up     = inc_en && (inc_tid == 1'(t));
        assign dn     = dec_en && (dec_tid == 1'(t));
        assign cnt[t] = c_q;

        always_ff @(posedge clk) begin
            if (!rst_n)          c_q <= '0;
            else if (up && !dn)  c_q <= c_q + 1'b1;
            else if (dn && !up)  c_q <= c_q - 1'b1;
        end

        AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            c_q <= CNT_W'(N)); // R9
        AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (dn && !up) |-> (c_q != '0)); // R9
    end
endmodule

// File: rtl/lfb_pool.sv
module lfb_pool #(
    parameter int NUM_ENT = 10,
    parameter int ADDR_W  = 26,
    parameter int BEATS   = 4,
    parameter int BEAT_W  = 128,
    parameter int TAG_W   = $clog2(NUM_ENT),
    parameter int BEAT_IW = $clog2(BEATS),
    parameter int LINE_W  = BEATS * BEAT_W,
    parameter int CNT_W   = $clog2(NUM_ENT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              miss_tid,
    output logic              mreq_valid,
    output logic [ADDR_W-1:0] mreq_addr,
    output logic [TAG_W-1:0]  mreq_tag,
    input  logic              fill_valid,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [BEAT_IW-1:0] fill_beat,
    input  logic [BEAT_W-1:0] fill_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LINE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cnt_t0,
    output logic [CNT_W-1:0]  cnt_t1
);
    logic [NUM_ENT-1:0] busy_v, want_v, hit_v, fill_v;
    logic [NUM_ENT-1:0] free_gnt, alloc_v, wr_gnt, grant_v;
    logic [NUM_ENT-1:0] tid_v;
    logic [ADDR_W-1:0]  addr_a [NUM_ENT];
    logic [LINE_W-1:0]  data_a [NUM_ENT];
    logic [TAG_W-1:0]   alloc_idx, wr_idx;
    logic               any_free, hit, miss_fire, do_alloc, wr_fire;
    logic [1:0][CNT_W-1:0] cnt;

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        assign hit_v[i]   = busy_v[i] && (addr_a[i] == miss_addr);
        assign fill_v[i]  = fill_valid && (fill_tag == TAG_W'(i));
        assign alloc_v[i] = do_alloc && free_gnt[i];
        assign grant_v[i] = wr_fire && wr_gnt[i];

        lfb_entry #(
            .ADDR_W (ADDR_W),
            .BEATS  (BEATS),
            .BEAT_W (BEAT_W),
            .BEAT_IW(BEAT_IW)
        ) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_en  (alloc_v[i]),
            .alloc_addr(miss_addr),
            .alloc_tid (miss_tid),
            .fill_en   (fill_v[i]),
            .fill_beat (fill_beat),
            .fill_data (fill_data),
            .wr_grant  (grant_v[i]),
            .busy      (busy_v[i]),
            .want_write(want_v[i]),
            .line_addr (addr_a[i]),
            .owner     (tid_v[i]),
            .line_data (data_a[i])
        );
    end

    lfb_pick #(.N(NUM_ENT), .IW(TAG_W)) u_free_pick (
        .req(~busy_v),
        .gnt(free_gnt),
        .any(any_free),
        .idx(alloc_idx)
    );

    lfb_pick #(.N(NUM_ENT), .IW(TAG_W)) u_wr_pick (
        .req(want_v),
        .gnt(wr_gnt),
        .any(wr_valid),
        .idx(wr_idx)
    );

    assign hit        = |hit_v;
    assign miss_ready = any_free;
    assign miss_fire  = miss_valid && miss_ready;
    assign do_alloc   = miss_fire && !hit;
    assign wr_fire    = wr_valid && wr_ready;
    assign wr_addr    = addr_a[wr_idx];
    assign wr_data    = data_a[wr_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mreq_valid <= 1'b0;
            mreq_addr  <= '0;
            mreq_tag   <= '0;
        end else begin
            mreq_valid <= do_alloc;
            if (do_alloc) begin
                mreq_addr <= miss_addr;
                mreq_tag  <= alloc_idx;
            end
        end
    end

    lfb_thread_count #(.N(NUM_ENT), .CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_en (do_alloc),
        .inc_tid(miss_tid),
        .dec_en (wr_fire),
        .dec_tid(tid_v[wr_idx]),
        .cnt    (cnt)
    );

    assign cnt_t0 = cnt[0];
    assign cnt_t1 = cnt[1];

    AST_ONE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_v)); // R2
    AST_REQ_AFTER_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        do_alloc |=> mreq_valid); // R2
    AST_MERGE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_fire && hit) |=> !mreq_valid); // R3
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy_v) |-> !miss_ready); // R4
    AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> wr_valid); // R7
    AST_CNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt_t0) + int'(cnt_t1)) == $countones(busy_v)); // R9
endmodule

// File: tb/sim_lfb_pool.sv
module sim_lfb_pool;
    localparam int NE = 4;
    localparam int AW = 12;
    localparam int BW = 8;
    localparam int TW = 2;
    localparam int LW = 32;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic          miss_ready;
    logic [AW-1:0] miss_addr = '0;
    logic          miss_tid = 1'b0;
    logic          mreq_valid;
    logic [AW-1:0] mreq_addr;
    logic [TW-1:0] mreq_tag;
    logic          fill_valid = 1'b0;
    logic [TW-1:0] fill_tag = '0;
    logic [1:0]    fill_beat = '0;
    logic [BW-1:0] fill_data = '0;
    logic          wr_valid;
    logic          wr_ready = 1'b0;
    logic [AW-1:0] wr_addr;
    logic [LW-1:0] wr_data;
    logic [CW-1:0] cnt_t0, cnt_t1;

    int  total = 0;
    int  bad = 0;
    bit  ended = 0;

    always #2 clk = ~clk;

    lfb_pool #(.NUM_ENT(NE), .ADDR_W(AW), .BEATS(4), .BEAT_W(BW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready),
        .miss_addr(miss_addr), .miss_tid(miss_tid),
        .mreq_valid(mreq_valid), .mreq_addr(mreq_addr), .mreq_tag(mreq_tag),
        .fill_valid(fill_valid), .fill_tag(fill_tag),
        .fill_beat(fill_beat), .fill_data(fill_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_t0(cnt_t0), .cnt_t1(cnt_t1)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [BW-1:0] beat_val(int seed, int b);
        return BW'(seed * 13 + b * 29 + 7);
    endfunction

    function automatic logic [LW-1:0] line_val(int seed);
        logic [LW-1:0] v = '0;
        for (int b = 0; b < 4; b++) v[b*BW +: BW] = beat_val(seed, b);
        return v;
    endfunction

    // beat order number p (0..23) as four 2-bit picks, first pick in low bits
    function automatic logic [7:0] beat_order(int p);
        int avail[4];
        int n = 4;
        int r = p;
        int f;
        int sel;
        logic [7:0] o = '0;
        for (int i = 0; i < 4; i++) avail[i] = i;
        for (int k = 0; k < 4; k++) begin
            f = 1;
            for (int j = 2; j < 4 - k; j++) f = f * j;
            sel = r / f;
            r = r % f;
            o[k*2 +: 2] = 2'(avail[sel]);
            for (int j = sel; j < n - 1; j++) avail[j] = avail[j+1];
            n--;
        end
        return o;
    endfunction

    task automatic do_miss(input logic [AW-1:0] a, input logic t, output logic acc);
        miss_valid = 1'b1;
        miss_addr  = a;
        miss_tid   = t;
        #1 acc = miss_ready;
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    task automatic do_fill(input logic [TW-1:0] tag, input logic [1:0] b, input logic [BW-1:0] d);
        fill_valid = 1'b1;
        fill_tag   = tag;
        fill_beat  = b;
        fill_data  = d;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic fill_line(input logic [TW-1:0] tag, input int seed);
        for (int b = 0; b < 4; b++) do_fill(tag, 2'(b), beat_val(seed, b));
    endtask

    task automatic do_write();
        wr_ready = 1'b1;
        @(negedge clk);
        wr_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic       acc;
        logic [7:0] ord;
        logic [AW-1:0] a;
        logic       t;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "miss_ready", 64'(miss_ready), 64'd1);
        chk("R1", "wr_valid", 64'(wr_valid), 64'd0);
        chk("R1", "mreq_valid", 64'(mreq_valid), 64'd0);
        chk("R1", "cnt_t0", 64'(cnt_t0), 64'd0);
        chk("R1", "cnt_t1", 64'(cnt_t1), 64'd0);

        // R5 / R6: sweep every beat arrival order
        for (int p = 0; p < 24; p++) begin
            a = AW'(p * 5 + 100);
            t = 1'(p % 2);
            ord = beat_order(p);
            do_miss(a, t, acc);
            chk("R4", "accept on empty pool", 64'(acc), 64'd1);
            chk("R2", "mreq_valid", 64'(mreq_valid), 64'd1);
            chk("R2", "mreq_tag", 64'(mreq_tag), 64'd0);
            chk("R2", "mreq_addr", 64'(mreq_addr), 64'(a));
            chk("R9", "cnt_t0", 64'(cnt_t0), 64'(t == 1'b0));
            chk("R9", "cnt_t1", 64'(cnt_t1), 64'(t == 1'b1));
            for (int k = 0; k < 4; k++) begin
                do_fill(2'd0, ord[k*2 +: 2], beat_val(p, int'(ord[k*2 +: 2])));
                if (k == 0) chk("R2", "mreq one cycle", 64'(mreq_valid), 64'd0);
                if (k < 3) chk("R6", "wr_valid early", 64'(wr_valid), 64'd0);
            end
            chk("R6", "wr_valid full", 64'(wr_valid), 64'd1);
            chk("R5", "wr_data", 64'(wr_data), 64'(line_val(p)));
            chk("R5", "wr_addr", 64'(wr_addr), 64'(a));
            do_write();
            chk("R8", "released wr_valid", 64'(wr_valid), 64'd0);
            chk("R8", "released ready", 64'(miss_ready), 64'd1);
            chk("R9", "released cnt", 64'(cnt_t0) + 64'(cnt_t1), 64'd0);
        end

        // R3 merge and R9 single-thread ownership
        do_miss(12'h200, 1'b1, acc);
        chk("R2", "tag 0", 64'(mreq_tag), 64'd0);
        do_miss(12'h201, 1'b1, acc);
        chk("R2", "tag 1", 64'(mreq_tag), 64'd1);
        do_miss(12'h200, 1'b0, acc);
        chk("R3", "merge accepted", 64'(acc), 64'd1);
        chk("R3", "merge no request", 64'(mreq_valid), 64'd0);
        chk("R3", "merge cnt_t0", 64'(cnt_t0), 64'd0);
        chk("R3", "merge cnt_t1", 64'(cnt_t1), 64'd2);
        do_miss(12'h202, 1'b1, acc);
        chk("R2", "tag 2", 64'(mreq_tag), 64'd2);
        do_miss(12'h203, 1'b1, acc);
        chk("R2", "tag 3", 64'(mreq_tag), 64'd3);
        chk("R9", "one thread owns all", 64'(cnt_t1), 64'd4);
        chk("R9", "other thread none", 64'(cnt_t0), 64'd0);
        chk("R4", "full not ready", 64'(miss_ready), 64'd0);

        // R4 miss while full
        do_miss(12'h204, 1'b0, acc);
        chk("R4", "full not accepted", 64'(acc), 64'd0);
        chk("R4", "full no request", 64'(mreq_valid), 64'd0);
        chk("R4", "full cnt_t0", 64'(cnt_t0), 64'd0);
        chk("R4", "full cnt_t1", 64'(cnt_t1), 64'd4);

        // R7 lowest index first, held without wr_ready
        fill_line(2'd3, 51);
        chk("R7", "entry 3 offered", 64'(wr_addr), 64'h203);
        fill_line(2'd1, 50);
        chk("R7", "wr_valid held", 64'(wr_valid), 64'd1);
        chk("R7", "lowest first addr", 64'(wr_addr), 64'h201);
        chk("R7", "lowest first data", 64'(wr_data), 64'(line_val(50)));
        do_write();
        chk("R7", "next addr", 64'(wr_addr), 64'h203);
        chk("R7", "next data", 64'(wr_data), 64'(line_val(51)));
        chk("R8", "ready after release", 64'(miss_ready), 64'd1);
        chk("R9", "cnt_t1 after release", 64'(cnt_t1), 64'd3);

        // R8 freed entry claimed again
        do_miss(12'h205, 1'b0, acc);
        chk("R8", "reclaim accepted", 64'(acc), 64'd1);
        chk("R8", "reclaim tag", 64'(mreq_tag), 64'd1);
        chk("R9", "cnt_t0 reclaim", 64'(cnt_t0), 64'd1);
        do_write();
        chk("R9", "cnt_t1 final", 64'(cnt_t1), 64'd2);
        chk("R6", "no more lines", 64'(wr_valid), 64'd0);

        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule